// File: doc/BRIEF.md
# SPI EEPROM Page-Write Sequencer

This block writes a run of 16-bit words into a serial EEPROM over a four-wire SPI link (clock, active-low select, data out, data in). A caller gives a start word index, a word count and a one-cycle start strobe. The caller also supplies the data words one at a time through a request/data handshake. The block first checks that the request fits inside the device. It then splits the run into bursts that never cross a device page.

Each burst begins with an access request that must be granted by an arbiter. Next the device status is polled until the device reports that it is not busy. The sequencer then sends a standalone write-enable command, followed by the write command, the byte address and the data words. After the burst it deselects the device, waits out the write-cycle time and gives up access. Completion and failure are both reported by a one-cycle done pulse, with the error flag valid alongside it.

Top module: `spi_eeprom_page_writer`

## Requirements
- R1: A start with offset >= WORD_SIZE, count = 0, or count > WORD_SIZE - offset ends with done and error high together, and no access request or select activity takes place.
- R2: The block raises acc_req before any select activity. If acc_gnt is not seen within GRANT_TRIES cycles, acc_req drops and done pulses with error high.
- R3: Every burst starts with one or more status frames. Each frame is the byte 0x05 followed by 8 clocks that read the status, most significant bit first. A further frame follows, after select goes high and then low, for as long as status bit 0 reads 1. After READY_TRIES frames that all read busy, select and acc_req drop and done pulses with error.
- R4: Once the device reads ready, the write-enable byte 0x06 is sent as a frame of its own.
- R5: The next frame starts with the write opcode 0x02, followed by the byte address (word index x 2, low ADDR_BITS bits, MSB first). When ADDR_BITS is 8 and the burst's first word index is 128 or more, the opcode is ORed with 0x08.
- R6: Each data word is sent low byte first, and each byte is sent MSB first.
- R7: A burst ends after the word whose index + 1 is a multiple of PAGE_BYTES/2, or after the last word. Select then goes high and stays high for WRITE_WAIT cycles. acc_req drops for at least one cycle, and any remaining words go out in a new granted burst. For a run that ends at a write frame, done rises exactly WRITE_WAIT + 2 cycles after select rose.
- R8: sck is high only while cs_n is low. mosi is low whenever cs_n is high.
- R9: word_req pulses for one cycle for each word sent, exactly count times per run. The word must be on word_data from the cycle after word_req is high.
- R10: done is a one-cycle pulse, error is high only with done, and at done cs_n is high, sck low and acc_req low.
- R11: After reset cs_n is high, and sck, mosi, acc_req, word_req, done and error are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a run |
| offset | input | $clog2(WORD_SIZE)+1 | First word index |
| count | input | $clog2(WORD_SIZE)+1 | Number of words |
| word_req | output | 1 | Pulse asking for the next data word |
| word_data | input | 16 | Data word, valid from the cycle after word_req |
| acc_req | output | 1 | Bus access request |
| acc_gnt | input | 1 | Bus access grant |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low device select |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Failure flag, valid with done |

## Verification
A rejected request gives its done pulse two clock edges after the start strobe. A grant timeout takes about GRANT_TRIES cycles. A run gives done exactly WRITE_WAIT + 2 cycles after the final select rise. The bench waits for done at falling edges and measures that last interval against the exact figure. Serial traffic is recorded byte by byte on rising sck and split into frames by rising cs_n, so the checks compare whole frame streams and do not depend on bit-level cycle positions. All counts (grant requests, word requests, frames) are read one falling edge after done, once everything has settled.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_A8    = 8'h08;

  typedef enum logic [1:0] {SH_IDLE, SH_LO, SH_HI} sh_state_t;

  typedef enum logic [4:0] {
    ST_IDLE, ST_REQ, ST_CSHI, ST_CSLO, ST_SHIFT, ST_RDSROP, ST_RDSRIN,
    ST_POLL, ST_WREN, ST_WROP, ST_ADDR, ST_FETCH, ST_FETCHW, ST_LOAD,
    ST_NEXT, ST_WWAIT, ST_REL, ST_FIN
  } wr_state_t;
endpackage

// File: rtl/eep_range_chk.sv
module eep_range_chk #(
  parameter int WORD_SIZE = 256,
  parameter int OFS_W     = 9
) (
  input  logic [OFS_W-1:0] offset,
  input  logic [OFS_W-1:0] count,
  output logic             bad
);
  localparam logic [OFS_W:0] WS = (OFS_W+1)'(WORD_SIZE);

  logic [OFS_W:0] room;

  always_comb begin
    room = WS - {1'b0, offset};
    bad  = ({1'b0, offset} >= WS) || (count == '0) || ({1'b0, count} > room);
  end
endmodule

// File: rtl/eep_bit_shifter.sv
module eep_bit_shifter
  import eep_pkg::*;
#(
  parameter int HALF_CYC = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        go,
  input  logic [4:0]  nbits,
  input  logic [15:0] dout,
  input  logic        miso,
  output logic        sck,
  output logic        mosi,
  output logic        fin,
  output logic        last_bit
);
  localparam int HC_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [HC_W-1:0] HC_LAST = HC_W'(HALF_CYC - 1);

  sh_state_t       st;
  logic [15:0]     sreg;
  logic [4:0]      left;
  logic [HC_W-1:0] hc;
  logic [15:0]     aligned;

  assign aligned = dout << (5'd16 - nbits);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SH_IDLE;
      sreg     <= '0;
      left     <= '0;
      hc       <= '0;
      sck      <= 1'b0;
      mosi     <= 1'b0;
      fin      <= 1'b0;
      last_bit <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (st)
        SH_IDLE: begin
          if (go) begin
            sreg <= aligned;
            left <= nbits;
            mosi <= aligned[15];
            sck  <= 1'b0;
            hc   <= '0;
            st   <= SH_LO;
          end
        end
        SH_LO: begin
          if (hc == HC_LAST) begin
            hc  <= '0;
            sck <= 1'b1;
            st  <= SH_HI;
          end else begin
            hc <= hc + 1'b1;
          end
        end
        SH_HI: begin
          if (hc == HC_LAST) begin
            hc       <= '0;
            last_bit <= miso;
            sck      <= 1'b0;
            if (left == 5'd1) begin
              mosi <= 1'b0;
              fin  <= 1'b1;
              st   <= SH_IDLE;
            end else begin
              sreg <= sreg << 1;
              mosi <= sreg[14];
              left <= left - 1'b1;
              st   <= SH_LO;
            end
          end else begin
            hc <= hc + 1'b1;
          end
        end
        default: st <= SH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_eeprom_page_writer.sv
module spi_eeprom_page_writer
  import eep_pkg::*;
#(
  parameter int WORD_SIZE   = 256,
  parameter int ADDR_BITS   = 8,
  parameter int PAGE_BYTES  = 32,
  parameter int HALF_CYC    = 2,
  parameter int GRANT_TRIES = 16,
  parameter int READY_TRIES = 4,
  parameter int WRITE_WAIT  = 200
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic [$clog2(WORD_SIZE):0]   offset,
  input  logic [$clog2(WORD_SIZE):0]   count,
  output logic                         word_req,
  input  logic [15:0]                  word_data,
  output logic                         acc_req,
  input  logic                         acc_gnt,
  output logic                         sck,
  output logic                         cs_n,
  output logic                         mosi,
  input  logic                         miso,
  output logic                         done,
  output logic                         error
);
  localparam int OFS_W   = $clog2(WORD_SIZE) + 1;
  localparam int PW      = PAGE_BYTES / 2;
  localparam int PW_LG   = $clog2(PW);
  localparam int T1      = (GRANT_TRIES > WRITE_WAIT) ? GRANT_TRIES : WRITE_WAIT;
  localparam int TMR_MAX = (T1 > HALF_CYC) ? T1 : HALF_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int PL_W    = $clog2(READY_TRIES + 1);

  localparam logic [TMR_W-1:0] HC_LAST = TMR_W'(HALF_CYC - 1);
  localparam logic [TMR_W-1:0] GT_LAST = TMR_W'(GRANT_TRIES - 1);
  localparam logic [TMR_W-1:0] WW_LAST = TMR_W'(WRITE_WAIT - 1);
  localparam logic [PL_W-1:0]  PL_LAST = PL_W'(READY_TRIES - 1);

  wr_state_t        state, ret_sh, ret_cs;
  logic [TMR_W-1:0] tmr;
  logic [PL_W-1:0]  polls;
  logic [OFS_W-1:0] cur, left, cur_nxt;
  logic             err_r, bad, page_end, a8;
  logic             sh_go, sh_fin, sh_last;
  logic [4:0]       sh_bits;
  logic [15:0]      sh_data, addr16;

  eep_range_chk #(.WORD_SIZE(WORD_SIZE), .OFS_W(OFS_W)) u_range (
    .offset(offset), .count(count), .bad(bad)
  );

  eep_bit_shifter #(.HALF_CYC(HALF_CYC)) u_shift (
    .clk(clk), .rst(rst), .go(sh_go), .nbits(sh_bits), .dout(sh_data),
    .miso(miso), .sck(sck), .mosi(mosi), .fin(sh_fin), .last_bit(sh_last)
  );

  // Address bit 8 travels inside the opcode only for 8-bit-address parts.
  generate
    if (ADDR_BITS == 8) begin : g_a8
      assign a8 = (cur >= OFS_W'(128));
    end else begin : g_no_a8
      assign a8 = 1'b0;
    end
  endgenerate

  assign cur_nxt  = cur + 1'b1;
  assign page_end = (cur_nxt[PW_LG-1:0] == '0);
  assign addr16   = 16'({cur, 1'b0});

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ret_sh   <= ST_IDLE;
      ret_cs   <= ST_IDLE;
      tmr      <= '0;
      polls    <= '0;
      cur      <= '0;
      left     <= '0;
      err_r    <= 1'b0;
      cs_n     <= 1'b1;
      acc_req  <= 1'b0;
      word_req <= 1'b0;
      done     <= 1'b0;
      error    <= 1'b0;
      sh_go    <= 1'b0;
      sh_bits  <= '0;
      sh_data  <= '0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      sh_go <= 1'b0;
      case (state)
        ST_IDLE: begin
          cs_n <= 1'b1;
          if (start) begin
            if (bad) begin
              err_r <= 1'b1;
              state <= ST_FIN;
            end else begin
              err_r <= 1'b0;
              cur   <= offset;
              left  <= count;
              tmr   <= '0;
              state <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          acc_req <= 1'b1;
          if (acc_req && acc_gnt) begin
            cs_n   <= 1'b0;
            tmr    <= '0;
            polls  <= '0;
            ret_cs <= ST_RDSROP;
            state  <= ST_CSLO;
          end else if (tmr == GT_LAST) begin
            acc_req <= 1'b0;
            err_r   <= 1'b1;
            state   <= ST_FIN;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_CSHI: begin
          if (tmr == HC_LAST) begin
            tmr   <= '0;
            cs_n  <= 1'b0;
            state <= ST_CSLO;
          end else begin
            cs_n <= 1'b1;
            tmr  <= tmr + 1'b1;
          end
        end
        ST_CSLO: begin
          if (tmr == HC_LAST) begin
            tmr   <= '0;
            state <= ret_cs;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (sh_fin) state <= ret_sh;
        end
        ST_RDSROP: begin
          sh_go   <= 1'b1;
          sh_data <= {8'h00, OP_RDSR};
          sh_bits <= 5'd8;
          ret_sh  <= ST_RDSRIN;
          state   <= ST_SHIFT;
        end
        ST_RDSRIN: begin
          sh_go   <= 1'b1;
          sh_data <= 16'h0000;
          sh_bits <= 5'd8;
          ret_sh  <= ST_POLL;
          state   <= ST_SHIFT;
        end
        ST_POLL: begin
          cs_n <= 1'b1;
          tmr  <= '0;
          if (!sh_last) begin
            ret_cs <= ST_WREN;
            state  <= ST_CSHI;
          end else if (polls == PL_LAST) begin
            acc_req <= 1'b0;
            err_r   <= 1'b1;
            state   <= ST_FIN;
          end else begin
            polls  <= polls + 1'b1;
            ret_cs <= ST_RDSROP;
            state  <= ST_CSHI;
          end
        end
        ST_WREN: begin
          sh_go   <= 1'b1;
          sh_data <= {8'h00, OP_WREN};
          sh_bits <= 5'd8;
          tmr     <= '0;
          ret_sh  <= ST_CSHI;
          ret_cs  <= ST_WROP;
          state   <= ST_SHIFT;
        end
        ST_WROP: begin
          sh_go   <= 1'b1;
          sh_data <= {8'h00, (OP_WRITE | (a8 ? OP_A8 : 8'h00))};
          sh_bits <= 5'd8;
          ret_sh  <= ST_ADDR;
          state   <= ST_SHIFT;
        end
        ST_ADDR: begin
          sh_go   <= 1'b1;
          sh_data <= addr16;
          sh_bits <= 5'(ADDR_BITS);
          ret_sh  <= ST_FETCH;
          state   <= ST_SHIFT;
        end
        ST_FETCH: begin
          word_req <= 1'b1;
          state    <= ST_FETCHW;
        end
        ST_FETCHW: begin
          word_req <= 1'b0;
          state    <= ST_LOAD;
        end
        ST_LOAD: begin
          sh_go   <= 1'b1;
          sh_data <= {word_data[7:0], word_data[15:8]};
          sh_bits <= 5'd16;
          ret_sh  <= ST_NEXT;
          state   <= ST_SHIFT;
        end
        ST_NEXT: begin
          cur  <= cur_nxt;
          left <= left - 1'b1;
          if ((left == OFS_W'(1)) || page_end) begin
            cs_n  <= 1'b1;
            tmr   <= '0;
            state <= ST_WWAIT;
          end else begin
            state <= ST_FETCH;
          end
        end
        ST_WWAIT: begin
          if (tmr == WW_LAST) begin
            tmr   <= '0;
            state <= ST_REL;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_REL: begin
          acc_req <= 1'b0;
          tmr     <= '0;
          state   <= (left == '0) ? ST_FIN : ST_REQ;
        end
        ST_FIN: begin
          done  <= 1'b1;
          error <= err_r;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eep_writer_chk.sv
module eep_writer_chk (
  input logic clk,
  input logic rst,
  input logic word_req,
  input logic acc_req,
  input logic sck,
  input logic cs_n,
  input logic mosi,
  input logic done,
  input logic error
);
  // R8
  sck_sel_chk: assert property (@(posedge clk) disable iff (rst) sck |-> !cs_n);

  // R8
  mosi_idle_chk: assert property (@(posedge clk) disable iff (rst) cs_n |-> !mosi);

  // R2
  bus_owned_chk: assert property (@(posedge clk) disable iff (rst) !acc_req |-> cs_n);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  // R10
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst) error |-> done);

  // R9
  word_req_pulse_chk: assert property (@(posedge clk) disable iff (rst) word_req |=> !word_req);

  // R9
  word_req_owned_chk: assert property (@(posedge clk) disable iff (rst) word_req |-> (acc_req && !cs_n));
endmodule

bind spi_eeprom_page_writer eep_writer_chk u_chk (
  .clk(clk), .rst(rst), .word_req(word_req), .acc_req(acc_req), .sck(sck),
  .cs_n(cs_n), .mosi(mosi), .done(done), .error(error)
);

// File: tb/spi_eeprom_page_writer_test.sv
module spi_eeprom_page_writer_test;
  localparam int WORD_SIZE   = 256;
  localparam int ADDR_BITS   = 8;
  localparam int PAGE_BYTES  = 32;
  localparam int HALF_CYC    = 2;
  localparam int GRANT_TRIES = 16;
  localparam int READY_TRIES = 4;
  localparam int WRITE_WAIT  = 200;
  localparam int OFS_W       = $clog2(WORD_SIZE) + 1;
  localparam int PW          = PAGE_BYTES / 2;
  localparam int MRK         = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [OFS_W-1:0] offset = '0;
  logic [OFS_W-1:0] count = '0;
  logic word_req;
  logic [15:0] word_data = 16'h0000;
  logic acc_req;
  logic acc_gnt;
  logic sck, cs_n, mosi, miso, done, error;

  logic gnt_en = 1'b0;

  int checks = 0;
  int errors = 0;

  logic [15:0] wdata [0:255];
  int wptr = 0;
  int nreq = 0;

  int log_b [0:1023];
  int nlog = 0;
  int exp_b [0:1023];
  int nexp = 0;
  int nburst = 0;

  int busy_left = 0;
  int fbits = 0;
  int fbytes = 0;
  logic [7:0] sh = 8'h00;
  logic [7:0] frm_op = 8'h00;

  int cyc = 0;
  int nrise = 0;
  int csrise_cyc = 0;
  int done_cyc = 0;
  logic prev_req = 1'b0;
  logic prev_cs = 1'b1;

  always #4 clk = ~clk;

  assign acc_gnt = gnt_en & acc_req;
  assign miso = (frm_op == 8'h05) && (fbytes >= 1) && (busy_left > 0);

  spi_eeprom_page_writer #(
    .WORD_SIZE(WORD_SIZE), .ADDR_BITS(ADDR_BITS), .PAGE_BYTES(PAGE_BYTES),
    .HALF_CYC(HALF_CYC), .GRANT_TRIES(GRANT_TRIES), .READY_TRIES(READY_TRIES),
    .WRITE_WAIT(WRITE_WAIT)
  ) uut (
    .clk(clk), .rst(rst), .start(start), .offset(offset), .count(count),
    .word_req(word_req), .word_data(word_data), .acc_req(acc_req),
    .acc_gnt(acc_gnt), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .done(done), .error(error)
  );

  // Word supplier: next word presented from the cycle after word_req.
  always @(posedge clk) begin
    if (start) begin
      wptr <= 0;
      nreq <= 0;
    end else if (word_req) begin
      word_data <= wdata[wptr[7:0]];
      wptr      <= wptr + 1;
      nreq      <= nreq + 1;
    end
  end

  // Device model: records bytes per frame, answers status reads.
  always @(negedge cs_n) begin
    fbits  = 0;
    fbytes = 0;
    frm_op = 8'h00;
  end

  always @(posedge sck) begin
    sh = {sh[6:0], mosi};
    fbits = fbits + 1;
    if (fbits % 8 == 0) begin
      if (nlog < 1024) log_b[nlog] = int'(sh);
      nlog = nlog + 1;
      if (fbytes == 0) frm_op = sh;
      fbytes = fbytes + 1;
    end
  end

  always @(posedge cs_n) begin
    if (fbytes > 0) begin
      if (nlog < 1024) log_b[nlog] = MRK;
      nlog = nlog + 1;
      if (frm_op == 8'h05 && busy_left > 0) busy_left = busy_left - 1;
      fbytes = 0;
    end
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (acc_req && !prev_req) nrise = nrise + 1;
    if (cs_n && !prev_cs) csrise_cyc = cyc;
    if (done) done_cyc = cyc;
    prev_req = acc_req;
    prev_cs  = cs_n;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic void push(input int v);
    if (nexp < 1024) exp_b[nexp] = v;
    nexp = nexp + 1;
  endfunction

  task automatic build_exp(input int off, input int cnt, input int busy);
    int idx = off;
    int endi = off + cnt;
    int nb = busy;
    nexp = 0;
    nburst = 0;
    while (idx < endi) begin
      for (int b = 0; b <= nb; b++) begin
        push(5); push(0); push(MRK);
      end
      nb = 0;
      push(6); push(MRK);
      push(2 | ((idx >= 128) ? 8 : 0));
      push((idx * 2) & 255);
      do begin
        push(int'(wdata[idx - off][7:0]));
        push(int'(wdata[idx - off][15:8]));
        idx = idx + 1;
      end while (idx < endi && (idx % PW) != 0);
      push(MRK);
      nburst = nburst + 1;
    end
  endtask

  task automatic cmp_stream(input string req);
    int mm = -1;
    chk(nlog == nexp, req, "frame byte count", nlog, nexp);
    for (int i = 0; i < nexp && i < nlog && i < 1024; i++)
      if (mm < 0 && log_b[i] != exp_b[i]) mm = i;
    if (mm >= 0) chk(1'b0, req, "stream byte mismatch", log_b[mm], exp_b[mm]);
    else chk(1'b1, req, "stream bytes", 0, 0);
  endtask

  task automatic run_write(input int off, input int cnt, input int busy,
                           input bit gnt, output bit err_o, output bit got);
    gnt_en    = gnt;
    busy_left = busy;
    nlog      = 0;
    nrise     = 0;
    got       = 1'b0;
    err_o     = 1'b0;
    for (int i = 0; i < 256; i++) wdata[i] = 16'(16'hA55A ^ (i * 16'h0F1D));
    @(negedge clk);
    offset = OFS_W'(off);
    count  = OFS_W'(cnt);
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 40000 && !got; k++) begin
      @(negedge clk);
      if (done) begin
        got   = 1'b1;
        err_o = error;
      end
    end
    @(negedge clk);
    busy_left = 0;
  endtask

  task automatic t_reset;
    chk(cs_n == 1'b1, "R11", "cs_n after reset", int'(cs_n), 1);
    chk(!sck && !mosi, "R11", "sck|mosi after reset", int'(sck | mosi), 0);
    chk(!acc_req && !word_req, "R11", "req lines after reset", int'(acc_req | word_req), 0);
    chk(!done && !error, "R11", "done|error after reset", int'(done | error), 0);
  endtask

  task automatic t_bounds(input int off, input int cnt);
    bit e, g;
    run_write(off, cnt, 0, 1'b1, e, g);
    chk(g && e, "R1", "rejected with error", int'(e), 1);
    chk(nlog == 0, "R1", "no serial bytes", nlog, 0);
    chk(nrise == 0, "R1", "no access request", nrise, 0);
  endtask

  task automatic t_grant_timeout;
    bit e, g;
    run_write(5, 2, 0, 1'b0, e, g);
    chk(g && e, "R2", "grant timeout error", int'(e), 1);
    chk(nlog == 0, "R2", "no bytes without grant", nlog, 0);
    chk(nrise == 1 && !acc_req, "R2", "request dropped", int'(acc_req), 0);
  endtask

  task automatic t_ready_exhaust;
    bit e, g;
    run_write(7, 1, 100, 1'b1, e, g);
    nexp = 0;
    for (int b = 0; b < READY_TRIES; b++) begin
      push(5); push(0); push(MRK);
    end
    chk(g && e, "R3", "busy device error", int'(e), 1);
    cmp_stream("R3");
    chk(!acc_req && cs_n, "R3", "access released", int'(acc_req), 0);
    chk(nreq == 0, "R9", "no words requested", nreq, 0);
  endtask

  task automatic t_run(input string req, input int off, input int cnt, input int busy);
    bit e, g;
    run_write(off, cnt, busy, 1'b1, e, g);
    build_exp(off, cnt, busy);
    chk(g && !e, req, "done without error", int'(e), 0);
    cmp_stream(req);
    chk(nreq == cnt, "R9", "word requests", nreq, cnt);
    chk(nrise == nburst, "R7", "granted bursts", nrise, nburst);
    chk(done_cyc - csrise_cyc == WRITE_WAIT + 2, "R7", "write wait to done",
        done_cyc - csrise_cyc, WRITE_WAIT + 2);
    chk(cs_n && !sck && !mosi && !acc_req, "R10", "idle lines at end",
        int'({cs_n, sck, mosi, acc_req}), 8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors = errors + 1;
    $display("FAIL R10 watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_bounds(256, 1);
    t_bounds(10, 0);
    t_bounds(250, 7);
    t_grant_timeout();
    t_ready_exhaust();
    // R4 R5 R6: short run with two busy polls
    t_run("R6", 3, 2, 2);
    // R7: run spanning a page boundary
    t_run("R7", 14, 4, 0);
    // R5: high half of an 8-bit-address part
    t_run("R5", 130, 1, 1);
    // R1 R4: largest legal run at the end of the device
    t_run("R4", 250, 6, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule